// File: doc/BRIEF.md
# RS-485 Half-Duplex Direction Controller

This block sits between a UART and a half-duplex RS-485 transceiver and decides which way the shared pair is driven. While the line is idle the transceiver listens and the UART receiver is enabled. When the transmit queue reports data, the controller turns the local receiver off. In the same step it turns on the transceiver driver and the UART transmitter, and then strobes characters from the queue into the UART holding register whenever that register is free.

When the queue runs dry, the controller stops strobing loads but keeps the driver on. It waits for the UART to report that its shift register has sent the final stop bit, and only that event hands the pair back to receive mode. If new data appears during this wait, the controller resumes sending without ever releasing the line. All four direction outputs come straight from flip-flops.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While reset is held and after it is released with no data queued, xcvr_de=0, uart_tx_en=0, xcvr_re=1, uart_rx_en=1 and tx_load=0.
- R2: In receive mode, tx_avail=1 at a clock edge sets xcvr_de=1 and uart_tx_en=1 and clears xcvr_re and uart_rx_en from the next cycle.
- R3: tx_load is 1 exactly in the cycles where the controller is actively sending (not draining), tx_avail=1 and tx_hold_empty=1. It is never 1 in receive mode or while draining.
- R4: While actively sending, tx_avail=0 together with tx_hold_empty=1 at an edge moves the controller into the drain wait. Loads stop and xcvr_de stays 1.
- R5: While draining, tx_shift_done=1 with tx_avail=0 at an edge returns to receive mode in the next cycle: xcvr_de=0, uart_tx_en=0, xcvr_re=1, uart_rx_en=1.
- R6: tx_shift_done has no effect in receive mode or while actively sending. Direction outputs and tx_load are unchanged by it.
- R7: While draining, tx_avail=1 at an edge returns to active sending even if tx_shift_done=1 in the same cycle. xcvr_de never drops.
- R8: xcvr_de and xcvr_re are never 1 together. uart_tx_en always equals xcvr_de, and uart_rx_en always equals xcvr_re.
- R9: xcvr_de stays 1 in every cycle in which the UART shift register is still sending a frame, including the stop bit of the last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_avail | input | 1 | Transmit queue holds at least one character |
| tx_hold_empty | input | 1 | UART holding register can accept a character |
| tx_shift_done | input | 1 | One-cycle pulse: UART shifter finished its stop bit and is idle |
| tx_load | output | 1 | Move one character from the queue into the UART holding register |
| uart_tx_en | output | 1 | UART transmitter enable |
| uart_rx_en | output | 1 | UART receiver (and receive interrupt) enable |
| xcvr_de | output | 1 | Transceiver driver enable |
| xcvr_re | output | 1 | Transceiver receiver enable (active high) |

## Verification
A wrong internal state shows at the ports within one clock. A controller stuck in receive shows no driver enable the cycle after data is queued. A controller that drains early or late shows tx_load firing or missing in the cycle after the queue/holding-register condition. A premature release drops xcvr_de while the emulated shifter still has bits to send, which truncates the last character. The bench compares every output against a behavioural model on every cycle, so any such divergence is reported in the first cycle it appears, both in directed corner sequences and with a UART emulator that runs whole frames.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

    typedef enum logic [1:0] {
        ST_LISTEN = 2'd0,
        ST_SEND   = 2'd1,
        ST_DRAIN  = 2'd2
    } dir_state_e;

    typedef struct packed {
        dir_state_e st;
        logic       drv;   // driver / transmitter on
        logic       lsn;   // receiver on
    } dir_regs_t;

    localparam dir_regs_t DIR_RESET = '{st: ST_LISTEN, drv: 1'b0, lsn: 1'b1};

endpackage

// File: rtl/rs485_dir_next.sv
module rs485_dir_next
    import rs485_dir_pkg::*;
(
    input  dir_regs_t cur_q,
    input  logic      tx_avail,
    input  logic      tx_hold_empty,
    input  logic      tx_shift_done,
    output dir_regs_t nxt_d,
    output logic      load_o
);

    always_comb begin
        nxt_d  = cur_q;
        load_o = 1'b0;
        unique case (cur_q.st)
            ST_LISTEN: begin
                if (tx_avail) nxt_d.st = ST_SEND;
            end
            ST_SEND: begin
                load_o = tx_avail & tx_hold_empty;
                if (!tx_avail && tx_hold_empty) nxt_d.st = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (tx_avail)           nxt_d.st = ST_SEND;
                else if (tx_shift_done) nxt_d.st = ST_LISTEN;
            end
            default: nxt_d.st = ST_LISTEN;
        endcase
        // direction bits follow the next state so that the outputs are registered
        nxt_d.drv = (nxt_d.st != ST_LISTEN);
        nxt_d.lsn = (nxt_d.st == ST_LISTEN);
    end

endmodule

// File: rtl/rs485_dir_regs.sv
module rs485_dir_regs
    import rs485_dir_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dir_regs_t nxt_d,
    output dir_regs_t cur_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= DIR_RESET;
        else        cur_q <= nxt_d;
    end

endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
    import rs485_dir_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_avail,
    input  logic tx_hold_empty,
    input  logic tx_shift_done,
    output logic tx_load,
    output logic uart_tx_en,
    output logic uart_rx_en,
    output logic xcvr_de,
    output logic xcvr_re
);

    dir_regs_t state_q;
    dir_regs_t state_d;

    rs485_dir_next u_next (
        .cur_q        (state_q),
        .tx_avail     (tx_avail),
        .tx_hold_empty(tx_hold_empty),
        .tx_shift_done(tx_shift_done),
        .nxt_d        (state_d),
        .load_o       (tx_load)
    );

    rs485_dir_regs u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .nxt_d(state_d),
        .cur_q(state_q)
    );

    assign xcvr_de    = state_q.drv;
    assign uart_tx_en = state_q.drv;
    assign xcvr_re    = state_q.lsn;
    assign uart_rx_en = state_q.lsn;

    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xcvr_de && xcvr_re));

    // R3
    load_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (xcvr_de && tx_avail && tx_hold_empty));

    // R2
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xcvr_re && tx_avail) |=> xcvr_de);

    // R9
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xcvr_de) |-> ($past(tx_shift_done) && !$past(tx_avail)));

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.st == ST_DRAIN && tx_shift_done && !tx_avail) |=> xcvr_re);

endmodule

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;

    localparam int FRAME = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_avail = 1'b0;
    logic tx_hold_empty = 1'b1;
    logic tx_shift_done = 1'b0;
    logic tx_load, uart_tx_en, uart_rx_en, xcvr_de, xcvr_re;

    int tests = 0;
    int fails = 0;
    int mdl = 0;          // 0 listen, 1 send, 2 drain
    int emu_s = 0;        // bits left in emulated shifter
    string cur_req = "R1";

    always #5 clk = ~clk;

    rs485_dir_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tx_avail(tx_avail), .tx_hold_empty(tx_hold_empty),
        .tx_shift_done(tx_shift_done), .tx_load(tx_load), .uart_tx_en(uart_tx_en),
        .uart_rx_en(uart_rx_en), .xcvr_de(xcvr_de), .xcvr_re(xcvr_re)
    );

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) mdl = 0;
        else begin
            case (mdl)
                0: if (tx_avail) mdl = 1;
                1: if (!tx_avail && tx_hold_empty) mdl = 2;
                default: if (tx_avail) mdl = 1; else if (tx_shift_done) mdl = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(cur_req, "xcvr_de", xcvr_de, mdl != 0);
            check(cur_req, "xcvr_re", xcvr_re, mdl == 0);
            check("R3", "tx_load", tx_load, (mdl == 1) && tx_avail && tx_hold_empty);
            check("R8", "de&re", xcvr_de && xcvr_re, 0);
            check("R8", "uart_tx_en", uart_tx_en, xcvr_de);
            check("R8", "uart_rx_en", uart_rx_en, xcvr_re);
            if (emu_s > 0) check("R9", "de while shifting", xcvr_de, 1);
        end
    end

    task automatic step(logic av, logic he, logic sd, string req);
        @(posedge clk); #1;
        tx_avail = av; tx_hold_empty = he; tx_shift_done = sd; cur_req = req;
    endtask

    task automatic run_emu(int nbytes, int late, string req);
        int p = nbytes;
        int h = 0;
        int ld;
        int done;
        int idle = 0;
        emu_s = 0;
        cur_req = req;
        for (int cyc = 0; cyc < 400 && idle < 3; cyc++) begin
            @(negedge clk);
            ld = tx_load;
            @(posedge clk); #1;
            done = 0;
            if (emu_s > 0) begin
                emu_s--;
                if (emu_s == 0) done = 1;
            end
            if (ld != 0) begin p--; h = 1; end
            if (cyc == late) p++;
            if (emu_s == 0 && h != 0) begin emu_s = FRAME; h = 0; end
            tx_avail = (p > 0);
            tx_hold_empty = (h == 0);
            tx_shift_done = done[0];
            if (p == 0 && h == 0 && emu_s == 0 && done == 0 && cyc > late) idle++;
            else idle = 0;
        end
        @(negedge clk);
        check("R5", "receive after last frame", xcvr_re, 1);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: values during reset
        check("R1", "de in reset", xcvr_de, 0);
        check("R1", "re in reset", xcvr_re, 1);
        check("R1", "rx_en in reset", uart_rx_en, 1);
        check("R1", "tx_en in reset", uart_tx_en, 0);
        check("R1", "load in reset", tx_load, 0);
        rst_n = 1'b1;
        step(0, 1, 0, "R1");
        step(0, 1, 0, "R1");
        // R6: shift_done while listening
        step(0, 1, 1, "R6");
        step(0, 1, 0, "R6");
        // R2 start, R3 loads
        step(1, 1, 0, "R2");
        step(1, 1, 0, "R3");
        step(1, 0, 0, "R3");
        // R6: shift_done while actively sending
        step(1, 0, 1, "R6");
        step(0, 0, 1, "R6");
        // R4: queue empty and holding register free
        step(0, 1, 0, "R4");
        step(0, 1, 0, "R4");
        step(0, 0, 0, "R4");
        // R5: release
        step(0, 1, 1, "R5");
        step(0, 1, 0, "R5");
        // R7: new data while draining
        step(1, 1, 0, "R2");
        step(0, 1, 0, "R4");
        step(1, 1, 0, "R7");
        step(0, 1, 0, "R4");
        step(1, 1, 1, "R7");
        step(0, 1, 0, "R7");
        step(0, 1, 1, "R5");
        step(0, 1, 0, "R5");
        // R9: whole frames through a UART emulator
        run_emu(1, 0, "R9");
        run_emu(3, 0, "R9");
        run_emu(1, 6, "R7");
        run_emu(2, 25, "R9");
        step(0, 1, 0, "R1");
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule